// File: doc/BRIEF.md
# Cell Byte-to-Halfword Packer

This block takes a stream of 9-bit bytes, arriving one cell at a time, and packs them into 18-bit words. A narrow mode passes each byte through on its own. Cells pass in order, and the cell length is set from 8 to 128 bytes. In wide mode the block can also edit each cell so that an 8-bit cell format and a 16-bit cell format line up. In transmit direction it drops one fixed byte. In receive direction it adds one fixed zero byte. Whenever a cell's output byte count comes out odd, a zero pad byte completes the final word.

Bytes enter through a valid/ready handshake. The first byte of a cell carries a start flag. Once a cell is open, the block counts bytes against the programmed length and closes the cell by itself. The output is a registered word with a valid flag and a start-of-cell flag. There is no output backpressure. The byte order inside a word is chosen by a swap input, and that input may change at any clock.

Top module: `hw_packer`

## Requirements
- R1: In wide mode (`narrow`=0) with `edit_en`=0 and an even `cell_len`, each cell leaves as `cell_len`/2 words holding exactly its input bytes in arrival order.
- R2: In wide mode with `edit_en`=0 and an odd `cell_len`, one zero pad byte takes the second (later) byte slot of the cell's final word.
- R3: In wide mode with `edit_en`=1 and `tx_mode`=1, the 5th input byte of each cell is dropped. For an even `cell_len`, a zero pad byte also fills the second slot of the final word.
- R4: In wide mode with `edit_en`=1 and `tx_mode`=0, a zero byte is placed between input bytes 5 and 6, so it becomes output byte 6. For an even `cell_len`, a zero pad byte also closes the cell. `in_ready` is low for exactly one cycle per cell while the inserted byte is emitted.
- R5: With `swap_hi`=0, the earlier byte of a pair sits on `out_data[8:0]` and the later byte on `out_data[17:9]`. With `swap_hi`=1 the earlier byte sits on `out_data[17:9]`.
- R6: `swap_hi` is sampled at the clock edge that loads a word. A change therefore shows on the first word produced after the next edge, even in the middle of a cell.
- R7: In narrow mode (`narrow`=1), each byte leaves alone on `out_data[8:0]` with `out_data[17:9]`=0. No byte is added or removed, and `swap_hi` and `edit_en` have no effect.
- R8: `out_sof` is 1 only together with `out_valid`, and only on the first word of each cell.
- R9: A byte accepted while no cell is open is discarded unless `in_sof`=1. An `in_sof` on a byte inside an open cell is ignored.
- R10: During and right after reset, `out_valid`=0, `out_sof`=0 and `in_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte present |
| in_ready | output | 1 | Block accepts a byte this cycle |
| in_data | input | 9 | Input byte |
| in_sof | input | 1 | Marks the first byte of a cell |
| cell_len | input | 8 | Input cell length in bytes, 8..128 (8..126 with editing) |
| tx_mode | input | 1 | 1 = transmit direction (drop), 0 = receive direction (insert) |
| edit_en | input | 1 | Enables the byte drop/insert |
| swap_hi | input | 1 | 1 = earlier byte of a pair in the upper lane |
| narrow | input | 1 | 1 = 9-bit pass-through mode |
| out_valid | output | 1 | Output word valid |
| out_data | output | 18 | Output word |
| out_sof | output | 1 | Output word is the first of a cell |

## Verification
The hardest case to reach from the ports is a swap change that lands between the two bytes of one pair, or right on the edge that loads a word. The same difficulty holds when that edge also carries a pad or an inserted zero. To reach these cases, the bench sweeps every legal cell length in each of the four modes. For one length in three it flips `swap_hi` at random on every cycle. It also inserts random idle gaps, stray bytes before each cell, and a false start flag inside each cell. These vary the phase between the swap changes and the word boundaries. The expected lane order is taken from the swap value seen at each loading edge.

// File: rtl/hwp_pkg.sv
package hwp_pkg;
  localparam int BYTE_W = 9;
  localparam int WORD_W = 2 * BYTE_W;

  // Place two bytes into a word; 'earlier' is the byte that arrived first.
  function automatic logic [WORD_W-1:0] pair_word(
    input logic [BYTE_W-1:0] earlier,
    input logic [BYTE_W-1:0] later,
    input logic              hi_first
  );
    pair_word = hi_first ? {earlier, later} : {later, earlier};
  endfunction
endpackage

// File: rtl/hwp_cell_seq.sv
module hwp_cell_seq #(
  parameter int BYTE_W  = 9,
  parameter int LEN_W   = 8,
  parameter int DEL_IDX = 5,
  parameter int INS_IDX = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_sof,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              tx_i,
  input  logic              edit_i,
  output logic              ev_valid,
  output logic [BYTE_W-1:0] ev_byte,
  output logic              ev_start,
  output logic              ev_last
);
  localparam logic [LEN_W-1:0] DEL_AT    = LEN_W'(DEL_IDX);
  localparam logic [LEN_W-1:0] INS_AFTER = LEN_W'(INS_IDX - 1);

  logic [LEN_W-1:0] pos_q, pos_d, bidx;
  logic             ins_q, ins_d;
  logic             take, in_cell, acc, drop, last;

  always_comb begin
    in_ready = !ins_q;
    take     = in_valid && !ins_q;
    in_cell  = (pos_q != '0);
    acc      = take && (in_cell || in_sof);
    bidx     = pos_q + 1'b1;
    last     = acc && (bidx == len_i);
    drop     = acc && edit_i && tx_i && (bidx == DEL_AT);
    ins_d    = acc && edit_i && !tx_i && (bidx == INS_AFTER);
    if (last)      pos_d = '0;
    else if (acc)  pos_d = bidx;
    else           pos_d = pos_q;
    ev_valid = ins_q || (acc && !drop);
    ev_byte  = ins_q ? '0 : in_data;
    ev_start = acc && !in_cell;
    ev_last  = last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
      ins_q <= 1'b0;
    end else begin
      pos_q <= pos_d;
      ins_q <= ins_d;
    end
  end

  // R9
  pos_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_q == '0) || (pos_q < len_i));
  // R4
  ins_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ins_q |=> !ins_q);
endmodule

// File: rtl/hwp_lane_pack.sv
module hwp_lane_pack
  import hwp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid,
  input  logic [BYTE_W-1:0] ev_byte,
  input  logic              ev_start,
  input  logic              ev_last,
  input  logic              narrow_i,
  input  logic              swap_i,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_data,
  output logic              out_sof
);
  logic [BYTE_W-1:0] half_q;
  logic              half_vld_q, half_vld_d, half_ld;
  logic              sofp_q, sofp_d, sof_now;
  logic              emit;
  logic [WORD_W-1:0] word_d;
  logic              ov_q, os_q;
  logic [WORD_W-1:0] od_q;

  always_comb begin
    emit       = 1'b0;
    half_ld    = 1'b0;
    half_vld_d = half_vld_q;
    word_d     = od_q;
    if (ev_valid) begin
      if (narrow_i) begin
        emit   = 1'b1;
        word_d = {{BYTE_W{1'b0}}, ev_byte};
      end else if (half_vld_q) begin
        emit       = 1'b1;
        word_d     = pair_word(half_q, ev_byte, swap_i);
        half_vld_d = 1'b0;
      end else if (ev_last) begin
        emit   = 1'b1;
        word_d = pair_word(ev_byte, '0, swap_i);
      end else begin
        half_ld    = 1'b1;
        half_vld_d = 1'b1;
      end
    end
    sof_now = ev_start || sofp_q;
    sofp_d  = sof_now && !emit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_vld_q <= 1'b0;
      sofp_q     <= 1'b0;
      ov_q       <= 1'b0;
      os_q       <= 1'b0;
    end else begin
      half_vld_q <= half_vld_d;
      sofp_q     <= sofp_d;
      ov_q       <= emit;
      os_q       <= emit && sof_now;
    end
  end

  always_ff @(posedge clk) begin
    if (half_ld) half_q <= ev_byte;
    if (emit)    od_q   <= word_d;
  end

  assign out_valid = ov_q;
  assign out_data  = od_q;
  assign out_sof   = os_q;

  // R2
  cell_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_last && !narrow_i) |=> !half_vld_q);
  // R7
  narrow_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && narrow_i) |=> (ov_q && (od_q[WORD_W-1:BYTE_W] == '0)));
  // R8
  sof_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    os_q |-> ov_q);
  // R1
  no_ghost_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_valid |=> !ov_q);
endmodule

// File: rtl/hw_packer.sv
module hw_packer
  import hwp_pkg::*;
#(
  parameter int LEN_W   = 8,
  parameter int DEL_IDX = 5,
  parameter int INS_IDX = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_sof,
  input  logic [LEN_W-1:0]  cell_len,
  input  logic              tx_mode,
  input  logic              edit_en,
  input  logic              swap_hi,
  input  logic              narrow,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_data,
  output logic              out_sof
);
  logic              edit_eff;
  logic              ev_valid, ev_start, ev_last;
  logic [BYTE_W-1:0] ev_byte;

  assign edit_eff = edit_en && !narrow;

  hwp_cell_seq #(
    .BYTE_W (BYTE_W),
    .LEN_W  (LEN_W),
    .DEL_IDX(DEL_IDX),
    .INS_IDX(INS_IDX)
  ) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_valid(in_valid),
    .in_ready(in_ready),
    .in_data (in_data),
    .in_sof  (in_sof),
    .len_i   (cell_len),
    .tx_i    (tx_mode),
    .edit_i  (edit_eff),
    .ev_valid(ev_valid),
    .ev_byte (ev_byte),
    .ev_start(ev_start),
    .ev_last (ev_last)
  );

  hwp_lane_pack u_pack (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev_valid (ev_valid),
    .ev_byte  (ev_byte),
    .ev_start (ev_start),
    .ev_last  (ev_last),
    .narrow_i (narrow),
    .swap_i   (swap_hi),
    .out_valid(out_valid),
    .out_data (out_data),
    .out_sof  (out_sof)
  );
endmodule

// File: tb/hw_packer_tb.sv
module hw_packer_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_ready, in_sof;
  logic [8:0]  in_data;
  logic [7:0]  cell_len;
  logic        tx_mode, edit_en, swap_hi, narrow;
  logic        out_valid, out_sof;
  logic [17:0] out_data;

  int checks = 0;
  int errors = 0;
  int stall_cnt = 0;
  bit sw_rand = 0;
  bit swap_cap = 0;
  bit done = 0;
  string tag = "R1";

  logic [8:0] q_first[$];
  logic [8:0] q_second[$];
  bit         q_sof[$];
  bit         q_nar[$];

  always #2 clk = ~clk;

  hw_packer u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sof(in_sof), .cell_len(cell_len),
    .tx_mode(tx_mode), .edit_en(edit_en), .swap_hi(swap_hi), .narrow(narrow),
    .out_valid(out_valid), .out_data(out_data), .out_sof(out_sof)
  );

  // swap value seen by the edge that loads each word (R6)
  always @(posedge clk) swap_cap <= swap_hi;

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // output monitor: words, lane order (R5 R6), start flag (R8)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (!in_ready) stall_cnt++;
      if (!out_valid && out_sof) begin
        checks++; errors++;
        $display("FAIL R8 sof without valid: got 1 exp 0");
      end
      if (out_valid) begin
        if (q_first.size() == 0) begin
          checks++; errors++;
          $display("FAIL %s extra word: got %h exp none", tag, out_data);
        end else begin
          logic [17:0] exp_w;
          logic [8:0]  f, s;
          bit          xs, xn;
          f = q_first.pop_front(); s = q_second.pop_front();
          xs = q_sof.pop_front();  xn = q_nar.pop_front();
          if (xn) exp_w = {9'd0, f};
          else if (swap_cap) exp_w = {f, s};
          else exp_w = {s, f};
          checks++;
          if (out_data !== exp_w) begin
            errors++;
            $display("FAIL %s (R5 R6 R9) word: got %h exp %h", tag, out_data, exp_w);
          end
          checks++;
          if (out_sof !== xs) begin
            errors++;
            $display("FAIL R8 sof: got %0b exp %0b", out_sof, xs);
          end
        end
      end
    end
  end

  task automatic tick();
    @(negedge clk);
    if (sw_rand) swap_hi = 1'($urandom_range(0, 1));
  endtask

  task automatic put(input logic [8:0] d, input logic sof);
    in_valid = 1'b1; in_data = d; in_sof = sof;
    while (!in_ready) tick();
    tick();
    in_valid = 1'b0; in_sof = 1'b0;
  endtask

  // mode: 0 narrow, 1 plain wide, 2 wide transmit edit, 3 wide receive edit
  task automatic run_cell(input int mode, input int len, input int cno);
    logic [8:0] b[$];
    bit nar, ed, tx;
    int exp_stall;
    nar = (mode == 0);
    ed  = (mode >= 2) || (mode == 0 && (len % 2) == 1);
    tx  = (mode == 2);
    narrow = nar; edit_en = ed; tx_mode = tx; cell_len = 8'(len);
    if (nar) tag = "R7";
    else if (mode == 1) tag = (len % 2 == 0) ? "R1" : "R2";
    else if (mode == 2) tag = "R3";
    else tag = "R4";
    // expected byte stream from the requirements
    for (int i = 1; i <= len; i++) begin
      if (!(ed && !nar && tx && i == 5)) b.push_back({1'b1, 8'(cno * 13 + i)});
      if (ed && !nar && !tx && i == 5) b.push_back(9'd0);
    end
    if (!nar && (b.size() % 2 == 1)) b.push_back(9'd0);
    for (int k = 0; k < b.size(); k += (nar ? 1 : 2)) begin
      q_first.push_back(b[k]);
      q_second.push_back(nar ? 9'd0 : b[k+1]);
      q_sof.push_back(k == 0);
      q_nar.push_back(nar);
    end
    exp_stall = (ed && !nar && !tx) ? 1 : 0;
    sw_rand = (len % 3 == 2);
    if (!sw_rand) swap_hi = (len % 3 == 1);
    stall_cnt = 0;
    // stray bytes outside a cell are dropped (R9)
    put(9'h0AA, 1'b0);
    put(9'h155, 1'b0);
    for (int i = 1; i <= len; i++) begin
      if ($urandom_range(0, 3) == 0) tick();
      put({1'b1, 8'(cno * 13 + i)}, (i == 1) || (i == 3));
    end
    repeat (4) tick();
    checks++;
    if (q_first.size() != 0) begin
      errors++;
      $display("FAIL %s missing words: got %0d left exp 0", tag, q_first.size());
    end
    q_first.delete(); q_second.delete(); q_sof.delete(); q_nar.delete();
    checks++;
    if (stall_cnt != exp_stall) begin
      errors++;
      $display("FAIL R4 stall cycles: got %0d exp %0d", stall_cnt, exp_stall);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got timeout exp finish");
    summary();
  end

  initial begin
    int cno = 0;
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; in_sof = 1'b0;
    cell_len = 8'd53; tx_mode = 1'b0; edit_en = 1'b0; swap_hi = 1'b0; narrow = 1'b0;
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_sof !== 1'b0 || in_ready !== 1'b1) begin
      errors++;
      $display("FAIL R10 reset: got v%0b s%0b r%0b exp v0 s0 r1", out_valid, out_sof, in_ready);
    end
    rst_n = 1'b1;
    tick();
    checks++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      errors++;
      $display("FAIL R10 after release: got v%0b r%0b exp v0 r1", out_valid, in_ready);
    end
    for (int mode = 0; mode < 4; mode++) begin
      for (int len = 8; len <= ((mode >= 2) ? 126 : 128); len++) begin
        run_cell(mode, len, cno);
        cno++;
      end
    end
    done = 1;
    summary();
  end
endmodule